// File: doc/BRIEF.md
# Min-Sum LDPC Codeword Decoder

This block corrects one received codeword of a short systematic binary low-density parity-check code. The code is fixed when the chip is built: seven code bits, the first four carrying the message and the last three carrying parity, tied together by three parity equations. A channel front end hands over one signed soft value per code bit through a valid/ready handshake. The block then refines its belief in each bit by exchanging messages along the edges of the code's graph until either every parity equation holds or an iteration limit is hit.

Every iteration takes two clock cycles. In the first cycle each bit node adds its channel value to all messages from its parity nodes, takes a hard decision and checks the syndrome. If the syndrome is clear, or the limit has been reached, the cycle ends the decode. Otherwise each bit node registers one outgoing message per edge. In the second cycle each parity node applies the min-sum rule to these messages and registers the replies. At the end of a decode the block raises a one-cycle done pulse with the decided bits, a flag for a clean syndrome and the number of iterations used.

Top module: `ldpc_minsum_dec`

## Requirements
- R1: While reset is held and right after it, in_ready is 1, out_done is 0, and out_bits, out_converged and out_iters are 0.
- R2: A word is taken on a rising edge where in_valid and in_ready are both 1. in_ready then stays 0 until the cycle in which out_done is 1.
- R3: in_valid pulses while in_ready is 0 are ignored. They do not change the result or the timing of the decode in progress.
- R4: in_llr holds seven 6-bit two's complement values, with bit j at bits [6j+5:6j]. An input of -32 is treated as -31, and all messages saturate to the range -31..+31.
- R5: Bit j is decided 1 exactly when its channel value plus all its incoming parity messages is negative. A sum of zero decides 0.
- R6: Before each iteration the syndrome is tested. If the hard decisions of the channel values already satisfy every equation, the decode ends with out_iters 0 and out_converged 1.
- R7: In each iteration, the message a bit sends on an edge is its total minus the message that came in on that edge. A parity node replies on each edge with the lowest magnitude among its other edges. The sign of that reply is negative when an odd number of its other inputs are negative.
- R8: When the syndrome is still nonzero after MAX_ITER iterations, the decode ends with out_converged 0 and out_iters equal to MAX_ITER. out_iters never exceeds MAX_ITER.
- R9: out_done is high for exactly one cycle, 1+2k rising edges after the accepting edge, where k is out_iters. out_bits keeps its value in the cycles where out_done is 0.
- R10: In the cycle where out_done is 1, in_ready is also 1, and a new word can be taken on the next edge.
- R11: Bit j sits in column j of three parity equations. The equations cover bits {0,1,2,4}, {0,1,3,5} and {0,2,3,6}. out_converged is 1 only when out_bits gives even parity on all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Channel values on in_llr are valid |
| in_ready | output | 1 | Block is idle and can take a word |
| in_llr | input | 42 | Seven 6-bit signed channel values, bit j in slice j |
| out_done | output | 1 | One-cycle pulse at the end of a decode |
| out_bits | output | 7 | Decided code bits, bit j is code bit j |
| out_converged | output | 1 | All parity equations hold for out_bits |
| out_iters | output | 4 | Iterations used (width follows MAX_ITER) |

## Verification
The end of one decode and the start of the next can fall in the same cycle. out_done and in_ready are both high, and a word offered then is taken on the very next edge. The bench keeps a queue of words and offers the next one whenever its model expects in_ready. This makes almost every decode start on the done cycle of the one before. The model tracks ready, done and the results cycle by cycle, so a lost or doubled load, a stale result or a wrong latency shows up as a mismatch at that cycle. Junk valid pulses sent while busy check that nothing is taken outside the idle state.

// File: rtl/ldpc_pkg.sv
package ldpc_pkg;

  // Fixed code: number of bits and number of parity equations
  localparam int N = 7;
  localparam int M = 3;

  // Parity equations, bit j of row i set when code bit j joins equation i
  localparam logic [M-1:0][N-1:0] H_ROWS = {7'b1001101, 7'b0101011, 7'b0010111};

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_VN   = 2'd1,
    ST_CN   = 2'd2
  } dec_state_e;

  // Column j of the matrix as a mask over equations
  function automatic logic [M-1:0] col_mask(input int j);
    logic [M-1:0] r;
    for (int i = 0; i < M; i++) r[i] = H_ROWS[i][j];
    return r;
  endfunction

endpackage

// File: rtl/ldpc_var_unit.sv
module ldpc_var_unit #(
  parameter int W = 6,
  parameter int SW = 9,
  parameter int M = 3,
  parameter logic [M-1:0] COL = '1
) (
  input  logic [W-1:0]          llr,
  input  logic [M-1:0][W-1:0]   c2v,
  output logic [M-1:0][W-1:0]   v2c,
  output logic                  hard
);

  localparam logic signed [SW-1:0] PMAX = SW'((1 << (W-1)) - 1);
  localparam logic signed [SW-1:0] NMAX = -PMAX;

  function automatic logic signed [SW-1:0] sx(input logic [W-1:0] v);
    return {{(SW-W){v[W-1]}}, v};
  endfunction

  logic signed [SW-1:0] acc;
  logic signed [SW-1:0] diff;

  // Total belief: channel value plus every incoming edge message
  always_comb begin
    acc = sx(llr);
    for (int i = 0; i < M; i++) begin
      if (COL[i]) acc = acc + sx(c2v[i]);
    end
  end

  assign hard = acc[SW-1];

  // Extrinsic message per edge, saturated to the symmetric range
  always_comb begin
    diff = '0;
    for (int i = 0; i < M; i++) begin
      v2c[i] = '0;
      if (COL[i]) begin
        diff = acc - sx(c2v[i]);
        if (diff > PMAX)      v2c[i] = {1'b0, {(W-1){1'b1}}};
        else if (diff < NMAX) v2c[i] = {1'b1, {(W-2){1'b0}}, 1'b1};
        else                  v2c[i] = diff[W-1:0];
      end
    end
  end

endmodule

// File: rtl/ldpc_check_unit.sv
module ldpc_check_unit #(
  parameter int W = 6,
  parameter int N = 7,
  parameter logic [N-1:0] ROW = '1
) (
  input  logic [N-1:0][W-1:0] v2c,
  output logic [N-1:0][W-1:0] c2v
);

  localparam int MW = W - 1;
  localparam int XW = (N > 1) ? $clog2(N) : 1;

  logic [MW-1:0] min1, min2, mag;
  logic [XW-1:0] min_idx;
  logic          sgn_all;
  logic [W-1:0]  absv;

  // First and second lowest magnitude plus the parity of all signs
  always_comb begin
    min1    = '1;
    min2    = '1;
    min_idx = '0;
    sgn_all = 1'b0;
    absv    = '0;
    mag     = '0;
    for (int j = 0; j < N; j++) begin
      if (ROW[j]) begin
        absv    = v2c[j][W-1] ? (~v2c[j] + 1'b1) : v2c[j];
        mag     = absv[MW-1:0];
        sgn_all = sgn_all ^ v2c[j][W-1];
        if (mag < min1) begin
          min2    = min1;
          min1    = mag;
          min_idx = XW'(j);
        end else if (mag < min2) begin
          min2 = mag;
        end
      end
    end
  end

  // Reply per edge excludes that edge's own contribution
  always_comb begin
    for (int j = 0; j < N; j++) begin
      c2v[j] = '0;
      if (ROW[j]) begin
        if ((sgn_all ^ v2c[j][W-1]) == 1'b1)
          c2v[j] = ~{1'b0, ((XW'(j) == min_idx) ? min2 : min1)} + 1'b1;
        else
          c2v[j] = {1'b0, ((XW'(j) == min_idx) ? min2 : min1)};
      end
    end
  end

endmodule

// File: rtl/ldpc_ctrl.sv
module ldpc_ctrl
  import ldpc_pkg::*;
#(
  parameter int MAX_ITER = 10,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          syn_zero,
  output logic          ready,
  output logic          load_en,
  output logic          v2c_en,
  output logic          c2v_en,
  output logic          fin_en,
  output logic [IW-1:0] iter
);

  dec_state_e    state_q, state_d;
  logic [IW-1:0] iter_q, iter_d;
  logic          at_cap;

  assign at_cap  = (iter_q == IW'(MAX_ITER));
  assign ready   = (state_q == ST_IDLE);
  assign load_en = ready & in_valid;
  assign iter    = iter_q;

  always_comb begin
    state_d = state_q;
    iter_d  = iter_q;
    v2c_en  = 1'b0;
    c2v_en  = 1'b0;
    fin_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          state_d = ST_VN;
          iter_d  = '0;
        end
      end
      ST_VN: begin
        if (syn_zero || at_cap) begin
          fin_en  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          v2c_en  = 1'b1;
          state_d = ST_CN;
        end
      end
      ST_CN: begin
        c2v_en  = 1'b1;
        iter_d  = iter_q + 1'b1;
        state_d = ST_VN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
    end else begin
      state_q <= state_d;
      iter_q  <= iter_d;
    end
  end

endmodule

// File: rtl/ldpc_minsum_dec.sv
module ldpc_minsum_dec
  import ldpc_pkg::*;
#(
  parameter int W = 6,
  parameter int MAX_ITER = 10,
  localparam int IW = $clog2(MAX_ITER + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N*W-1:0] in_llr,
  output logic           out_done,
  output logic [N-1:0]   out_bits,
  output logic           out_converged,
  output logic [IW-1:0]  out_iters
);

  localparam int SW = W + $clog2(M + 1) + 1;
  localparam logic [W-1:0] LLR_MINNEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] LLR_FLOOR  = {1'b1, {(W-2){1'b0}}, 1'b1};

  // Reset: asserted at once, released after two clean edges
  logic [1:0] rst_sync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  logic          load_en, v2c_en, c2v_en, fin_en, syn_zero;
  logic [IW-1:0] iter;

  ldpc_ctrl #(.MAX_ITER(MAX_ITER), .IW(IW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .in_valid(in_valid),
    .syn_zero(syn_zero),
    .ready   (in_ready),
    .load_en (load_en),
    .v2c_en  (v2c_en),
    .c2v_en  (c2v_en),
    .fin_en  (fin_en),
    .iter    (iter)
  );

  // Channel values, with the one unbalanced code clamped on entry
  logic [N-1:0][W-1:0] llr_q, llr_d;

  always_comb begin
    for (int j = 0; j < N; j++) begin
      llr_d[j] = (in_llr[j*W +: W] == LLR_MINNEG) ? LLR_FLOOR : in_llr[j*W +: W];
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     llr_q <= '0;
    else if (load_en) llr_q <= llr_d;
  end

  // Edge message stores, one slot per matrix position
  logic [M-1:0][N-1:0][W-1:0] c2v_q, c2v_new, c2v_d;
  logic [M-1:0][N-1:0][W-1:0] v2c_q, v2c_new;
  logic [N-1:0]               hard;
  logic [M-1:0]               syn;

  always_comb begin
    if (load_en) c2v_d = '0;
    else         c2v_d = c2v_new;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)               c2v_q <= '0;
    else if (load_en || c2v_en) c2v_q <= c2v_d;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    v2c_q <= '0;
    else if (v2c_en) v2c_q <= v2c_new;
  end

  // Bit nodes, one per column
  for (genvar j = 0; j < N; j++) begin : g_var
    logic [M-1:0][W-1:0] cin, vout;
    for (genvar i = 0; i < M; i++) begin : g_edge
      assign cin[i]          = c2v_q[i][j];
      assign v2c_new[i][j]   = vout[i];
    end
    ldpc_var_unit #(.W(W), .SW(SW), .M(M), .COL(col_mask(j))) u_var (
      .llr (llr_q[j]),
      .c2v (cin),
      .v2c (vout),
      .hard(hard[j])
    );
  end

  // Parity nodes, one per row
  for (genvar i = 0; i < M; i++) begin : g_chk
    ldpc_check_unit #(.W(W), .N(N), .ROW(H_ROWS[i])) u_chk (
      .v2c(v2c_q[i]),
      .c2v(c2v_new[i])
    );
    assign syn[i] = ^(hard & H_ROWS[i]);
  end

  assign syn_zero = ~|syn;

  // Result registers
  logic          done_q;
  logic [N-1:0]  bits_q;
  logic          conv_q;
  logic [IW-1:0] iters_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) done_q <= 1'b0;
    else          done_q <= fin_en;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      bits_q  <= '0;
      conv_q  <= 1'b0;
      iters_q <= '0;
    end else if (fin_en) begin
      bits_q  <= hard;
      conv_q  <= syn_zero;
      iters_q <= iter;
    end
  end

  assign out_done      = done_q;
  assign out_bits      = bits_q;
  assign out_converged = conv_q;
  assign out_iters     = iters_q;

endmodule

// File: rtl/ldpc_minsum_dec_chk.sv
module ldpc_minsum_dec_chk
  import ldpc_pkg::*;
#(
  parameter int MAX_ITER = 10,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_done,
  input logic [N-1:0]  out_bits,
  input logic          out_converged,
  input logic [IW-1:0] out_iters
);

  logic [M-1:0] chk_syn;
  always_comb begin
    for (int i = 0; i < M; i++) chk_syn[i] = ^(out_bits & H_ROWS[i]);
  end

  a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);

  a_r9_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_done |-> $stable(out_bits));

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> in_ready);

  a_r8_cap_count: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && !out_converged) |-> (out_iters == IW'(MAX_ITER)));

  a_r8_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (out_iters <= IW'(MAX_ITER)));

  a_r11_parity_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && out_converged) |-> (chk_syn == '0));

endmodule

bind ldpc_minsum_dec ldpc_minsum_dec_chk #(.MAX_ITER(MAX_ITER), .IW(IW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_done     (out_done),
  .out_bits     (out_bits),
  .out_converged(out_converged),
  .out_iters    (out_iters)
);

// File: tb/sim_ldpc_minsum_dec.sv
module sim_ldpc_minsum_dec;

  localparam int NB   = 7;
  localparam int WB   = 6;
  localparam int BMAX = 4;
  localparam int BIW  = $clog2(BMAX + 1);

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic [NB*WB-1:0]  in_llr;
  logic              out_done;
  logic [NB-1:0]     out_bits;
  logic              out_converged;
  logic [BIW-1:0]    out_iters;

  ldpc_minsum_dec #(.W(WB), .MAX_ITER(BMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_llr(in_llr), .out_done(out_done), .out_bits(out_bits),
    .out_converged(out_converged), .out_iters(out_iters)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Equations from R11, entry [i][j] for bit j
  int hrow [3][7] = '{'{1,1,1,0,1,0,0}, '{1,1,0,1,0,1,0}, '{1,0,1,1,0,0,1}};

  function automatic int sat31(input int x);
    if (x > 31) return 31;
    if (x < -31) return -31;
    return x;
  endfunction

  function automatic int absi(input int x);
    return (x < 0) ? -x : x;
  endfunction

  // Behavioural flooding min-sum (R4..R8)
  function automatic void ref_decode(input logic [NB*WB-1:0] v, output logic [NB-1:0] bits,
                                     output bit conv, output int iters);
    int llr [7];
    int c2v [3][7];
    int v2c [3][7];
    int tot [7];
    bit fin;
    bits = '0; conv = 0; iters = 0; fin = 0;
    for (int j = 0; j < 7; j++) begin
      llr[j] = int'($signed(v[j*WB +: WB]));
      if (llr[j] == -32) llr[j] = -31;
      for (int i = 0; i < 3; i++) c2v[i][j] = 0;
    end
    for (int it = 0; it <= BMAX; it++) begin
      if (!fin) begin
        bit bad;
        for (int j = 0; j < 7; j++) begin
          tot[j] = llr[j];
          for (int i = 0; i < 3; i++) if (hrow[i][j] != 0) tot[j] += c2v[i][j];
          bits[j] = (tot[j] < 0);
        end
        bad = 0;
        for (int i = 0; i < 3; i++) begin
          int p = 0;
          for (int j = 0; j < 7; j++) if (hrow[i][j] != 0 && bits[j]) p++;
          if (p % 2 != 0) bad = 1;
        end
        if (!bad) begin
          fin = 1; conv = 1; iters = it;
        end else if (it == BMAX) begin
          fin = 1; conv = 0; iters = it;
        end else begin
          for (int i = 0; i < 3; i++)
            for (int j = 0; j < 7; j++)
              v2c[i][j] = (hrow[i][j] != 0) ? sat31(tot[j] - c2v[i][j]) : 0;
          for (int i = 0; i < 3; i++)
            for (int j = 0; j < 7; j++) begin
              if (hrow[i][j] != 0) begin
                int mn = 31;
                bit sg = 0;
                for (int q = 0; q < 7; q++) begin
                  if (q != j && hrow[i][q] != 0) begin
                    sg ^= (v2c[i][q] < 0);
                    if (absi(v2c[i][q]) < mn) mn = absi(v2c[i][q]);
                  end
                end
                c2v[i][j] = sg ? -mn : mn;
              end
            end
        end
      end
    end
  endfunction

  function automatic logic [NB*WB-1:0] pack7(input int a0, a1, a2, a3, a4, a5, a6);
    logic [NB*WB-1:0] r;
    int t [7];
    t = '{a0, a1, a2, a3, a4, a5, a6};
    for (int j = 0; j < 7; j++) r[j*WB +: WB] = WB'(t[j]);
    return r;
  endfunction

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual busy expected idle");
    report();
  end

  logic [NB*WB-1:0] vq [$];
  int               rem;
  bit               exp_ready, exp_done;
  logic [NB-1:0]    eb, res_bits;
  bit               ec, res_conv;
  int               ei, res_iters, caps;
  bit               junk_cur, b2b_cur, sat_cur;
  bit               junk_res, b2b_res, sat_res;
  string            tags;

  initial begin
    in_valid = 0;
    in_llr   = '0;
    rst_n    = 0;
    caps     = 0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    checks++; if (in_ready !== 1'b1) begin errors++; $display("FAIL R1 ready in reset: actual %b expected 1", in_ready); end
    checks++; if (out_done !== 1'b0) begin errors++; $display("FAIL R1 done in reset: actual %b expected 0", out_done); end
    checks++; if (out_bits !== '0 || out_converged !== 1'b0 || out_iters !== '0) begin
      errors++; $display("FAIL R1 results in reset: actual %b/%b/%0d expected 0/0/0", out_bits, out_converged, out_iters);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);
    checks++; if (in_ready !== 1'b1 || out_done !== 1'b0) begin
      errors++; $display("FAIL R1 after reset: actual ready %b done %b expected 1 0", in_ready, out_done);
    end

    vq.push_back(pack7(31, 31, 31, 31, 31, 31, 31));        // R6 clean zero word
    vq.push_back(pack7(20, -20, -20, -20, 20, 20, 20));     // R6 clean nonzero word
    vq.push_back(pack7(0, 0, 0, 0, 0, 0, 0));               // R5 zero sums decide 0
    vq.push_back(pack7(-1, 1, 1, 1, 1, 1, 1));              // R7 one iteration
    vq.push_back(pack7(-32, 31, 31, 31, 31, 31, 31));       // R4 clamp on entry
    vq.push_back(pack7(-31, 31, 31, 31, 31, 31, 31));       // R4 same as above
    vq.push_back(pack7(10, 10, 10, 10, 10, 10, -3));        // R7 weak error
    vq.push_back(pack7(-5, 5, -5, 5, -5, 5, -5));           // mixed
    for (int r = 0; r < 300; r++) begin
      logic [NB*WB-1:0] x;
      for (int j = 0; j < 7; j++) x[j*WB +: WB] = WB'($urandom_range(0, 63));
      vq.push_back(x);
    end

    exp_ready = 1; exp_done = 0; rem = 0;
    junk_cur = 0; b2b_cur = 0; sat_cur = 0;
    junk_res = 0; b2b_res = 0; sat_res = 0;
    res_bits = '0; res_conv = 0; res_iters = 0;

    while (vq.size() > 0 || rem > 0 || exp_done) begin
      checks++;
      if (in_ready !== exp_ready) begin
        errors++; $display("FAIL R2 ready: actual %b expected %b", in_ready, exp_ready);
      end
      checks++;
      if (out_done !== exp_done) begin
        errors++; $display("FAIL R9 done: actual %b expected %b", out_done, exp_done);
      end
      if (exp_done) begin
        tags = "";
        if (res_iters == 0) tags = {tags, " R6"};
        else if (res_conv) tags = {tags, " R7"};
        else tags = {tags, " R8"};
        if (junk_res) tags = {tags, " R3"};
        if (b2b_res)  tags = {tags, " R10"};
        if (sat_res)  tags = {tags, " R4"};
        checks++;
        if (out_bits !== res_bits) begin
          errors++; $display("FAIL R5%s bits: actual %b expected %b", tags, out_bits, res_bits);
        end
        checks++;
        if (out_converged !== res_conv) begin
          errors++; $display("FAIL R11%s converged: actual %b expected %b", tags, out_converged, res_conv);
        end
        checks++;
        if (int'(out_iters) != res_iters) begin
          errors++; $display("FAIL R8%s iterations: actual %0d expected %0d", tags, out_iters, res_iters);
        end
      end

      // Drive for the coming edge
      if (exp_ready && vq.size() > 0) begin
        in_valid = 1;
        in_llr   = vq.pop_front();
      end else if (!exp_ready && ($urandom_range(0, 3) == 0)) begin
        in_valid = 1;                              // R3 junk while busy
        in_llr   = {$urandom(), $urandom()};
        junk_cur = 1;
      end else begin
        in_valid = 0;
      end

      // Expected state after the coming edge
      if (in_valid && exp_ready) begin
        ref_decode(in_llr, eb, ec, ei);
        b2b_cur = exp_done;
        sat_cur = 0;
        for (int j = 0; j < 7; j++) if (in_llr[j*WB +: WB] == 6'b100000) sat_cur = 1;
        junk_cur = 0;
        rem = 1 + 2 * ei;
        exp_ready = 0;
        exp_done = 0;
      end else if (rem > 0) begin
        rem--;
        if (rem == 0) begin
          exp_done = 1; exp_ready = 1;
          res_bits = eb; res_conv = ec; res_iters = ei;
          junk_res = junk_cur; b2b_res = b2b_cur; sat_res = sat_cur;
          if (!ec) caps++;
        end else begin
          exp_done = 0;
        end
      end else begin
        exp_done = 0;
      end
      @(negedge clk);
    end

    in_valid = 0;
    @(negedge clk);
    checks++;
    if (in_ready !== 1'b1 || out_done !== 1'b0) begin
      errors++; $display("FAIL R2 final idle: actual ready %b done %b expected 1 0", in_ready, out_done);
    end
    $display("info: %0d decodes ended at the iteration limit", caps);
    report();
  end

endmodule